// File: doc/BRIEF.md
# Critical-Traffic Frame Classifier with Per-Link Storage

This block looks at the header of each incoming Ethernet frame and decides which traffic class it belongs to: periodic, sporadic or aperiodic. It tests the upper 32 bits of the destination address against a marker value that is supplied on a port. A match means the frame is critical. For a critical frame, the EtherType selects periodic or sporadic handling. The low 16 bits of the destination address give the virtual-link number. The block then writes the frame's descriptor into the storage that belongs to that link.

Storage is organised by class:

- Each periodic link has one slot. A newer frame on the same link overwrites the slot.
- Each sporadic link has its own small FIFO.
- All non-critical frames share one FIFO.

Every store has a read port that presents the oldest or current entry. Frames that cannot be placed are dropped, and the block counts them. A frame arriving at a full queue is lost, and the block records this in a sticky overflow flag.

Top module: `vlc_frame_sorter`

## Requirements
- R1: A frame is critical when destination address bits [47:16] (address AND 0xFFFFFFFF0000) equal `cfg_marker`. Every non-critical frame goes to the shared aperiodic FIFO, whatever its EtherType.
- R2: For a critical frame, EtherType 0x88D7 selects periodic handling and EtherType 0x0800 selects sporadic handling. Any other EtherType drops the frame and counts it.
- R3: The link number is destination address bits [15:0]. By default, periodic links 0x0010..0x0013 map to slots 0..3 and sporadic links 0x0020 and 0x0021 map to queues 0 and 1. A critical frame whose link number is not in the table for its class is dropped and counted.
- R4: Writing a periodic slot stores the descriptor and sets its valid bit. A later write on the same link replaces the stored descriptor. A read clears the valid bit. When a read and a write reach the same slot in one cycle, the slot ends valid and holds the new descriptor.
- R5: Each sporadic queue holds `SPO_DEPTH` (default 4) descriptors. It is first-in first-out and presents its head with a valid flag. A read of an empty queue has no effect.
- R6: The aperiodic queue holds `APE_DEPTH` (default 8) descriptors and follows the same ordering and presentation rules as R5.
- R7: A frame that arrives at a full queue is discarded, and that queue's overflow flag is set. Fullness is judged before any read in the same cycle. The flag stays set until reset.
- R8: `drop_cnt` counts frames dropped under R2 and R3. It saturates at 2^`CNT_W`-1 (255 by default).
- R9: After reset, every slot and queue is empty, both overflow flags are clear and `drop_cnt` is zero.
- R10: A header accepted at a clock edge is visible on the read ports and counters immediately after that edge. A read request takes effect at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_marker | input | 32 | Critical-traffic marker compared with address bits [47:16] |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_dst | input | 48 | Destination address |
| hdr_etype | input | 16 | EtherType |
| hdr_desc | input | DW | Frame descriptor to store |
| per_rd | input | NUM_PER | Read (consume) strobe per periodic slot |
| per_valid | output | NUM_PER | Slot holds an unread descriptor |
| per_desc | output | NUM_PER*DW | Slot descriptors, slot i at [i*DW +: DW] |
| spo_rd | input | NUM_SPO | Pop strobe per sporadic queue |
| spo_valid | output | NUM_SPO | Sporadic queue not empty |
| spo_desc | output | NUM_SPO*DW | Sporadic queue heads |
| spo_ovf | output | NUM_SPO | Sticky overflow flag per sporadic queue |
| ape_rd | input | 1 | Pop strobe for the aperiodic queue |
| ape_valid | output | 1 | Aperiodic queue not empty |
| ape_desc | output | DW | Aperiodic queue head |
| ape_ovf | output | 1 | Sticky overflow flag of the aperiodic queue |
| drop_cnt | output | CNT_W | Saturating count of dropped critical frames |

## Verification
The hardest case to reach is a full queue that receives a frame and a pop request in the same cycle. The stimulus has to fill one sporadic link exactly to its depth while that link's reads are held low. It then issues the write and the pop together. Both must be seen to act: the frame is lost, the overflow flag sets, and the head still advances. Counter saturation is reached by sending several hundred malformed critical headers in a row. After these directed passes, a random mix of links, EtherTypes, markers and read strobes runs against a behavioural queue model and is compared every cycle.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  localparam int ADDR_W = 48;
  localparam int VLID_W = 16;
  localparam int MARK_W = 32;
  localparam logic [ADDR_W-1:0] CRIT_MASK = 48'hFFFF_FFFF_0000;
  localparam logic [15:0] ETYPE_PERIODIC = 16'h88D7;
  localparam logic [15:0] ETYPE_SPORADIC = 16'h0800;

  typedef enum logic [1:0] {
    CLS_APER = 2'd0,
    CLS_PER  = 2'd1,
    CLS_SPO  = 2'd2,
    CLS_BAD  = 2'd3
  } frame_cls_e;
endpackage

// File: rtl/vlc_classify.sv
module vlc_classify
  import vlc_pkg::*;
#(
  parameter int NUM_PER = 4,
  parameter int NUM_SPO = 2,
  parameter logic [NUM_PER*VLID_W-1:0] PER_VLIDS = '0,
  parameter logic [NUM_SPO*VLID_W-1:0] SPO_VLIDS = '0
) (
  input  logic              hdr_valid,
  input  logic [ADDR_W-1:0] dst,
  input  logic [15:0]       etype,
  input  logic [MARK_W-1:0] marker,
  output logic [NUM_PER-1:0] per_wr,
  output logic [NUM_SPO-1:0] spo_wr,
  output logic               ape_wr,
  output logic               drop
);
  logic [VLID_W-1:0]  vlid;
  logic               crit;
  logic [NUM_PER-1:0] per_hit;
  logic [NUM_SPO-1:0] spo_hit;
  frame_cls_e         cls;

  assign vlid = dst[VLID_W-1:0];
  assign crit = ((dst & CRIT_MASK) == {marker, {VLID_W{1'b0}}});

  // one comparator per table entry
  for (genvar p = 0; p < NUM_PER; p++) begin : g_per_cmp
    assign per_hit[p] = (vlid == PER_VLIDS[p*VLID_W +: VLID_W]);
  end
  for (genvar s = 0; s < NUM_SPO; s++) begin : g_spo_cmp
    assign spo_hit[s] = (vlid == SPO_VLIDS[s*VLID_W +: VLID_W]);
  end

  always_comb begin
    if (!crit)                        cls = CLS_APER;
    else if (etype == ETYPE_PERIODIC) cls = CLS_PER;
    else if (etype == ETYPE_SPORADIC) cls = CLS_SPO;
    else                              cls = CLS_BAD;
  end

  always_comb begin
    per_wr = '0;
    spo_wr = '0;
    ape_wr = 1'b0;
    drop   = 1'b0;
    if (hdr_valid) begin
      unique case (cls)
        CLS_APER: ape_wr = 1'b1;
        CLS_PER: begin
          per_wr = per_hit;
          drop   = ~|per_hit;
        end
        CLS_SPO: begin
          spo_wr = spo_hit;
          drop   = ~|spo_hit;
        end
        default: drop = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/vlc_slot.sv
module vlc_slot #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic          valid,
  output logic [DW-1:0] rdata
);
  logic          valid_q, valid_d;
  logic [DW-1:0] data_q;

  always_comb begin
    valid_d = valid_q;
    if (rd) valid_d = 1'b0;
    if (wr) valid_d = 1'b1;   // write wins over same-cycle read
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr) data_q <= wdata;
  end

  assign valid = valid_q;
  assign rdata = data_q;

  a_r4_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (valid_q && data_q == $past(wdata)));
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr) |=> !valid_q);
endmodule

// File: rtl/vlc_fifo.sv
module vlc_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic          valid,
  output logic [DW-1:0] rdata,
  output logic          ovf
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             ovf_q, ovf_d;
  logic             full, empty, do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count_q == FULL_CNT);
  assign empty   = (count_q == '0);
  assign do_push = push && !full;    // fullness judged before the pop
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_ptr_d = do_push ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = do_pop  ? bump(rd_ptr_q) : rd_ptr_q;
    count_d  = count_q;
    if (do_push && !do_pop)      count_d = count_q + 1'b1;
    else if (do_pop && !do_push) count_d = count_q - 1'b1;
    ovf_d = ovf_q | (push & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
      ovf_q    <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wdata;
  end

  assign valid = !empty;
  assign rdata = mem[rd_ptr_q];
  assign ovf   = ovf_q;

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  a_r7_full_push_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> ($stable(count_q) && ovf_q));
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL_CNT);
  a_r5_empty_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> $stable(rd_ptr_q));
endmodule

// File: rtl/vlc_frame_sorter.sv
module vlc_frame_sorter
  import vlc_pkg::*;
#(
  parameter int DW        = 16,
  parameter int NUM_PER   = 4,
  parameter int NUM_SPO   = 2,
  parameter int SPO_DEPTH = 4,
  parameter int APE_DEPTH = 8,
  parameter int CNT_W     = 8,
  parameter logic [NUM_PER*16-1:0] PER_VLIDS = {16'h0013, 16'h0012, 16'h0011, 16'h0010},
  parameter logic [NUM_SPO*16-1:0] SPO_VLIDS = {16'h0021, 16'h0020}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           cfg_marker,
  input  logic                  hdr_valid,
  input  logic [47:0]           hdr_dst,
  input  logic [15:0]           hdr_etype,
  input  logic [DW-1:0]         hdr_desc,
  input  logic [NUM_PER-1:0]    per_rd,
  output logic [NUM_PER-1:0]    per_valid,
  output logic [NUM_PER*DW-1:0] per_desc,
  input  logic [NUM_SPO-1:0]    spo_rd,
  output logic [NUM_SPO-1:0]    spo_valid,
  output logic [NUM_SPO*DW-1:0] spo_desc,
  output logic [NUM_SPO-1:0]    spo_ovf,
  input  logic                  ape_rd,
  output logic                  ape_valid,
  output logic [DW-1:0]         ape_desc,
  output logic                  ape_ovf,
  output logic [CNT_W-1:0]      drop_cnt
);
  logic [1:0]         rst_sync_q;
  logic               rst_ni;
  logic [NUM_PER-1:0] per_wr;
  logic [NUM_SPO-1:0] spo_wr;
  logic               ape_wr;
  logic               drop;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  vlc_classify #(
    .NUM_PER(NUM_PER), .NUM_SPO(NUM_SPO),
    .PER_VLIDS(PER_VLIDS), .SPO_VLIDS(SPO_VLIDS)
  ) u_cls (
    .hdr_valid(hdr_valid), .dst(hdr_dst), .etype(hdr_etype), .marker(cfg_marker),
    .per_wr(per_wr), .spo_wr(spo_wr), .ape_wr(ape_wr), .drop(drop)
  );

  for (genvar i = 0; i < NUM_PER; i++) begin : g_slot
    vlc_slot #(.DW(DW)) u_slot (
      .clk(clk), .rst_n(rst_ni), .wr(per_wr[i]), .wdata(hdr_desc),
      .rd(per_rd[i]), .valid(per_valid[i]), .rdata(per_desc[i*DW +: DW])
    );
  end

  for (genvar j = 0; j < NUM_SPO; j++) begin : g_spo
    vlc_fifo #(.DW(DW), .DEPTH(SPO_DEPTH)) u_q (
      .clk(clk), .rst_n(rst_ni), .push(spo_wr[j]), .wdata(hdr_desc),
      .pop(spo_rd[j]), .valid(spo_valid[j]), .rdata(spo_desc[j*DW +: DW]),
      .ovf(spo_ovf[j])
    );
  end

  vlc_fifo #(.DW(DW), .DEPTH(APE_DEPTH)) u_ape (
    .clk(clk), .rst_n(rst_ni), .push(ape_wr), .wdata(hdr_desc),
    .pop(ape_rd), .valid(ape_valid), .rdata(ape_desc), .ovf(ape_ovf)
  );

  always_comb begin
    cnt_d = cnt_q;
    if (drop && (cnt_q != {CNT_W{1'b1}})) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
  assign drop_cnt = cnt_q;

  a_r2_single_outcome: assert property (@(posedge clk) disable iff (!rst_ni)
    hdr_valid |-> $onehot({|per_wr, |spo_wr, ape_wr, drop}));
  a_r3_one_slot: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(per_wr) && $onehot0(spo_wr));
  a_r1_idle_no_store: assert property (@(posedge clk) disable iff (!rst_ni)
    !hdr_valid |=> ($stable(drop_cnt) && $stable(ape_ovf) && $stable(spo_ovf)));
  a_r8_cnt_never_falls: assert property (@(posedge clk) disable iff (!rst_ni)
    ##1 (drop_cnt >= $past(drop_cnt)));
endmodule

// File: tb/vlc_frame_sorter_test.sv
`timescale 1ns/1ps
module vlc_frame_sorter_test;
  localparam int DW = 16, NP = 4, NS = 2, SD = 4, AD = 8;
  localparam logic [31:0] MARK = 32'hA5A5_0001;
  localparam logic [15:0] ET_P = 16'h88D7, ET_S = 16'h0800, ET_X = 16'h86DD;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic hdr_valid;
  logic [47:0] hdr_dst;
  logic [15:0] hdr_etype;
  logic [DW-1:0] hdr_desc;
  logic [NP-1:0] per_rd, per_valid;
  logic [NP*DW-1:0] per_desc;
  logic [NS-1:0] spo_rd, spo_valid, spo_ovf;
  logic [NS*DW-1:0] spo_desc;
  logic ape_rd, ape_valid, ape_ovf;
  logic [DW-1:0] ape_desc;
  logic [7:0] drop_cnt;

  vlc_frame_sorter uut (
    .clk(clk), .rst_n(rst_n), .cfg_marker(MARK), .hdr_valid(hdr_valid),
    .hdr_dst(hdr_dst), .hdr_etype(hdr_etype), .hdr_desc(hdr_desc),
    .per_rd(per_rd), .per_valid(per_valid), .per_desc(per_desc),
    .spo_rd(spo_rd), .spo_valid(spo_valid), .spo_desc(spo_desc), .spo_ovf(spo_ovf),
    .ape_rd(ape_rd), .ape_valid(ape_valid), .ape_desc(ape_desc), .ape_ovf(ape_ovf),
    .drop_cnt(drop_cnt)
  );

  // reference model
  bit            m_per_v [NP];
  logic [DW-1:0] m_per_d [NP];
  logic [DW-1:0] m_spo [NS][$];
  logic [DW-1:0] m_ape [$];
  bit            m_spo_ovf [NS];
  bit            m_ape_ovf;
  int            m_drop;
  int            total = 0, bad = 0;
  bit            done = 0;
  string         phase = "";

  function automatic logic [47:0] mk_dst(bit crit, logic [15:0] vl);
    return {crit ? MARK : (MARK ^ 32'h0100_0000), vl};
  endfunction

  function automatic int per_idx(logic [15:0] vl);
    return (vl >= 16'h0010 && vl <= 16'h0013) ? int'(vl - 16'h0010) : -1;
  endfunction

  function automatic int spo_idx(logic [15:0] vl);
    return (vl == 16'h0020 || vl == 16'h0021) ? int'(vl - 16'h0020) : -1;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, phase, act, exp);
    end
  endtask

  task automatic compare();
    for (int i = 0; i < NP; i++) begin
      chk("R4 slot valid", 64'(per_valid[i]), 64'(m_per_v[i]));
      if (m_per_v[i]) chk("R4 slot data", 64'(per_desc[i*DW +: DW]), 64'(m_per_d[i]));
    end
    for (int i = 0; i < NS; i++) begin
      chk("R5 sporadic valid", 64'(spo_valid[i]), 64'(m_spo[i].size() > 0));
      if (m_spo[i].size() > 0) chk("R5 sporadic head", 64'(spo_desc[i*DW +: DW]), 64'(m_spo[i][0]));
      chk("R7 sporadic overflow", 64'(spo_ovf[i]), 64'(m_spo_ovf[i]));
    end
    chk("R6 aperiodic valid", 64'(ape_valid), 64'(m_ape.size() > 0));
    if (m_ape.size() > 0) chk("R6 aperiodic head", 64'(ape_desc), 64'(m_ape[0]));
    chk("R7 aperiodic overflow", 64'(ape_ovf), 64'(m_ape_ovf));
    chk("R8 drop count", 64'(drop_cnt), 64'(m_drop));
  endtask

  task automatic model(bit v, logic [47:0] dst, logic [15:0] et, logic [DW-1:0] d,
                       logic [NP-1:0] prd, logic [NS-1:0] srd, bit ard);
    bit sfull [NS];
    bit afull;
    bit dropped = 0;
    for (int i = 0; i < NP; i++) if (prd[i]) m_per_v[i] = 0;
    for (int i = 0; i < NS; i++) begin
      sfull[i] = (m_spo[i].size() == SD);
      if (srd[i] && m_spo[i].size() > 0) void'(m_spo[i].pop_front());
    end
    afull = (m_ape.size() == AD);
    if (ard && m_ape.size() > 0) void'(m_ape.pop_front());
    if (v) begin
      if (dst[47:16] != MARK) begin
        if (afull) m_ape_ovf = 1; else m_ape.push_back(d);
      end else if (et == ET_P) begin
        int k = per_idx(dst[15:0]);
        if (k < 0) dropped = 1; else begin m_per_v[k] = 1; m_per_d[k] = d; end
      end else if (et == ET_S) begin
        int k = spo_idx(dst[15:0]);
        if (k < 0) dropped = 1;
        else if (sfull[k]) m_spo_ovf[k] = 1;
        else m_spo[k].push_back(d);
      end else dropped = 1;
    end
    if (dropped && m_drop < 255) m_drop++;
  endtask

  // called just after a falling edge; result checked at the next falling edge
  task automatic step(bit v, logic [47:0] dst, logic [15:0] et, logic [DW-1:0] d,
                      logic [NP-1:0] prd, logic [NS-1:0] srd, bit ard);
    hdr_valid = v; hdr_dst = dst; hdr_etype = et; hdr_desc = d;
    per_rd = prd; spo_rd = srd; ape_rd = ard;
    model(v, dst, et, d, prd, srd, ard);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    step(0, 48'h0, 16'h0, '0, '0, '0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NP; i++) begin m_per_v[i] = 0; m_per_d[i] = '0; end
    for (int i = 0; i < NS; i++) m_spo_ovf[i] = 0;
    m_ape_ovf = 0; m_drop = 0;
    rst_n = 0; hdr_valid = 0; hdr_dst = '0; hdr_etype = '0; hdr_desc = '0;
    per_rd = '0; spo_rd = '0; ape_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    phase = "R9 reset state";
    compare();

    phase = "R1 R10 non-critical goes aperiodic";
    step(1, mk_dst(0, 16'h0010), ET_P, 16'h1001, '0, '0, 0);
    step(1, mk_dst(0, 16'h0020), ET_S, 16'h1002, '0, '0, 0);
    step(1, 48'h1234_5678_0011, ET_X, 16'h1003, '0, '0, 1);
    step(0, 48'h0, 16'h0, '0, '0, '0, 1);
    step(0, 48'h0, 16'h0, '0, '0, '0, 1);
    step(0, 48'h0, 16'h0, '0, '0, '0, 1);

    phase = "R2 EtherType selects class";
    step(1, mk_dst(1, 16'h0010), ET_P, 16'h2001, '0, '0, 0);
    step(1, mk_dst(1, 16'h0020), ET_S, 16'h2002, '0, '0, 0);
    step(1, mk_dst(1, 16'h0010), ET_X, 16'h2003, '0, '0, 0);
    step(1, mk_dst(1, 16'h0013), ET_P, 16'h2004, '0, 2'b01, 0);

    phase = "R3 unknown link numbers";
    step(1, mk_dst(1, 16'h0055), ET_P, 16'h3001, '0, '0, 0);
    step(1, mk_dst(1, 16'h0020), ET_P, 16'h3002, '0, '0, 0);
    step(1, mk_dst(1, 16'h0011), ET_S, 16'h3003, '0, '0, 0);
    step(1, mk_dst(1, 16'h0014), ET_P, 16'h3004, '0, '0, 0);

    phase = "R4 slot overwrite and read";
    step(1, mk_dst(1, 16'h0011), ET_P, 16'h4001, '0, '0, 0);
    step(1, mk_dst(1, 16'h0011), ET_P, 16'h4002, '0, '0, 0);
    step(0, 48'h0, 16'h0, '0, 4'b0010, '0, 0);
    step(1, mk_dst(1, 16'h0011), ET_P, 16'h4003, 4'b0010, '0, 0);
    step(0, 48'h0, 16'h0, '0, 4'b1111, '0, 0);

    phase = "R5 R7 sporadic fill, overflow with pop";
    for (int n = 0; n < SD; n++) step(1, mk_dst(1, 16'h0021), ET_S, 16'h5000 + 16'(n), '0, '0, 0);
    step(1, mk_dst(1, 16'h0021), ET_S, 16'h50AA, '0, 2'b10, 0);
    step(1, mk_dst(1, 16'h0021), ET_S, 16'h50BB, '0, '0, 0);
    for (int n = 0; n < SD + 2; n++) step(0, 48'h0, 16'h0, '0, '0, 2'b11, 0);

    phase = "R6 R7 aperiodic fill and overflow";
    for (int n = 0; n < AD + 2; n++) step(1, mk_dst(0, 16'h0100), ET_X, 16'h6000 + 16'(n), '0, '0, 0);
    step(1, mk_dst(0, 16'h0100), ET_X, 16'h60FF, '0, '0, 1);
    for (int n = 0; n < AD + 1; n++) step(0, 48'h0, 16'h0, '0, '0, '0, 1);

    phase = "R8 drop counter saturation";
    for (int n = 0; n < 300; n++) step(1, mk_dst(1, 16'h0099), ET_P, 16'h7000, '0, '0, 0);
    idle();

    phase = "random mix R1 R2 R3 R4 R5 R6";
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] vl, et;
      int r = $urandom_range(0, 9);
      vl = (r < 4) ? 16'h0010 + 16'($urandom_range(0, 3)) :
           (r < 8) ? 16'h0020 + 16'($urandom_range(0, 1)) : 16'($urandom);
      r = $urandom_range(0, 9);
      et = (r < 4) ? ET_P : (r < 8) ? ET_S : ET_X;
      step($urandom_range(0, 3) != 0, mk_dst($urandom_range(0, 4) != 0, vl), et,
           16'($urandom), 4'($urandom) & 4'($urandom),
           2'($urandom) & 2'($urandom), $urandom_range(0, 3) == 0);
    end
    idle();
    finish_run();
  end
endmodule